// File: doc/BRIEF.md
# Linear Systolic Multiply-Accumulate Chain

A one-dimensional row of identical processing elements (PEs) that computes convolutions (FIR filtering) and matrix-vector style dot products on a stream of signed samples. Samples enter PE 0 and flow toward the last PE. Each PE stage holds one partial-sum register, and that register passes its value to the next PE on every accepted input beat. The last PE's partial sum is the array output.

Before streaming starts, a configuration port loads into each PE a 16-bit signed coefficient, a routing mode and a sample delay depth. Each PE has a programmable delay line on its sample path. The depth sets the spacing, in beats, between that PE's tap and the next PE's tap. A run of zero taps in a filter therefore costs one longer delay instead of a whole PE. The input and output are valid/ready streams. The input ready signal follows the output ready signal, so a stall from downstream freezes the whole chain at once.

Top module: `sysmac_chain`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_data` is 0. Every PE is in pass mode with coefficient 0 and depth 1.
- R2: `in_ready` equals `out_ready` in every cycle. A beat is a cycle with `in_valid` and `in_ready` both high, and all chain state advances only on beats.
- R3: Mode code 1 is convolution. Let P_i be the sum of the depths of PEs 0..i-1. After beat n, the output is the sum, over convolution PEs, of c_i·x[n−3−P_i], exact in 40-bit two's complement.
- R4: `cfg_depth_m1` holds the depth minus one, so the depth ranges from 1 to 8. With depth D on PE i, the tap of PE i+1 lags the tap of PE i by D beats.
- R5: Mode codes 0 and 3 are pass modes. A PE in a pass mode adds nothing to the partial sum, whatever its coefficient.
- R6: Mode code 2 is row accumulation. The PE sums c_i·x over the beats of a row. The row-last flag travels with its sample. On the marked beat, the PE adds its row total into the passing partial sum and clears its accumulator. The total reaches the output after the row's last beat n, with the same lag 3+P_i as in R3.
- R7: A configuration write is ignored in any cycle where `in_valid` is high.
- R8: A configuration write with `cfg_pe_index` of 4 or more is ignored.
- R9: While `out_ready` is low, `out_valid` and `out_data` hold their values, and no sample is taken or lost.
- R10: If a valid output is accepted (`out_ready` high) in a cycle with no beat, `out_valid` falls in the next cycle. No result is presented twice.
- R11: `out_valid` rises on the beat that brings the number of beats since the last accepted configuration write (or reset) to 4+D0+D1+D2. An accepted write clears that count, clears `out_valid` and clears the row accumulators.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_pe_index | input | 3 | Target PE of the write |
| cfg_coeff | input | 16 | Signed coefficient |
| cfg_depth_m1 | input | 3 | Sample delay depth minus one |
| cfg_mode | input | 2 | 0/3 pass, 1 convolution, 2 row accumulate |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input may be accepted |
| in_sample | input | 16 | Signed input sample |
| in_row_last | input | 1 | Marks the last sample of a row |
| out_valid | output | 1 | Output result valid |
| out_ready | input | 1 | Downstream accepts the output |
| out_data | output | 40 | Signed partial-sum result |

## Verification
The bench sweeps the delay depths of the first three PEs over the values 1, 3 and 8, with mixed modes. A wrong tap index in the delay line would then show up as a shifted term in the sum, and a wrong fill count as `out_valid` rising a beat early or late. Rows of different lengths check that the row-last flag stays aligned with its sample. A design that let the flag skip a delay would emit a row total on the wrong beat or mix totals from adjacent rows. Stall, drain and blocked-write cases catch a chain that advances while stalled, a result presented twice, and a configuration corrupted during streaming or by an out-of-range index. Full-scale negative operands catch a truncated or unsigned product.

// File: rtl/sysmac_pkg.sv
package sysmac_pkg;

    typedef enum logic [1:0] {
        MODE_PASS = 2'd0,
        MODE_CONV = 2'd1,
        MODE_MATV = 2'd2,
        MODE_RSVD = 2'd3
    } mode_e;

endpackage

// File: rtl/sysmac_dline.sv
module sysmac_dline #(
    parameter int W    = 17,
    parameter int MAXD = 8,
    parameter int DW   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          beat,
    input  logic [DW-1:0] depth_m1,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout
);
    // Physical length is MAXD+1; tap index depth_m1+1 gives depth+1 stages,
    // one of which balances the partial-sum register of the PE.
    typedef struct packed {
        logic [MAXD:0][W-1:0] sh;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (beat) begin
            st_d.sh[0] = din;
            for (int k = 1; k <= MAXD; k++) begin
                st_d.sh[k] = st_q.sh[k-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.sh[int'(depth_m1) + 1];

endmodule

// File: rtl/sysmac_pe.sv
module sysmac_pe
    import sysmac_pkg::*;
#(
    parameter int SW   = 16,
    parameter int AW   = 40,
    parameter int MAXD = 8,
    parameter int DW   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 beat,
    input  logic                 clr_acc,
    input  logic signed [SW-1:0] coeff,
    input  logic [DW-1:0]        depth_m1,
    input  mode_e                mode,
    input  logic signed [SW-1:0] x_in,
    input  logic                 last_in,
    input  logic signed [AW-1:0] psum_in,
    output logic signed [SW-1:0] x_out,
    output logic                 last_out,
    output logic signed [AW-1:0] psum_out
);
    typedef struct packed {
        logic signed [AW-1:0] psum;
        logic signed [AW-1:0] acc;
    } st_t;

    st_t st_d, st_q;

    logic signed [2*SW-1:0] prod;
    logic signed [AW-1:0]   prod_e;

    assign prod   = coeff * x_in;
    assign prod_e = {{(AW-2*SW){prod[2*SW-1]}}, prod};

    always_comb begin
        st_d = st_q;
        if (beat) begin
            case (mode)
                MODE_CONV: st_d.psum = psum_in + prod_e;
                MODE_MATV: begin
                    if (last_in) begin
                        st_d.psum = psum_in + st_q.acc + prod_e;
                        st_d.acc  = '0;
                    end else begin
                        st_d.psum = psum_in;
                        st_d.acc  = st_q.acc + prod_e;
                    end
                end
                default:   st_d.psum = psum_in;
            endcase
        end
        if (clr_acc) st_d.acc = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign psum_out = st_q.psum;

    sysmac_dline #(.W(SW+1), .MAXD(MAXD), .DW(DW)) u_dline (
        .clk      (clk),
        .rst_n    (rst_n),
        .beat     (beat),
        .depth_m1 (depth_m1),
        .din      ({last_in, x_in}),
        .dout     ({last_out, x_out})
    );

endmodule

// File: rtl/sysmac_chain.sv
module sysmac_chain
    import sysmac_pkg::*;
#(
    parameter int NUM_PE = 4,
    parameter int SW     = 16,
    parameter int AW     = 40,
    parameter int MAXD   = 8,
    parameter int IW     = $clog2(NUM_PE) + 1,
    parameter int DW     = $clog2(MAXD)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_valid,
    input  logic [IW-1:0]        cfg_pe_index,
    input  logic signed [SW-1:0] cfg_coeff,
    input  logic [DW-1:0]        cfg_depth_m1,
    input  logic [1:0]           cfg_mode,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic signed [SW-1:0] in_sample,
    input  logic                 in_row_last,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic signed [AW-1:0] out_data
);
    localparam int PIW  = $clog2(NUM_PE);
    localparam int FW   = $clog2(NUM_PE + NUM_PE * MAXD + 1) + 1;
    localparam int CFGW = SW + DW + 2;

    typedef struct packed {
        logic signed [SW-1:0] coeff;
        logic [DW-1:0]        dm1;
        mode_e                mode;
    } pecfg_t;

    typedef struct packed {
        pecfg_t [NUM_PE-1:0] cfg;
        logic [FW-1:0]       fill;
        logic                oval;
    } st_t;

    st_t st_d, st_q;

    logic                 beat;
    logic                 cfg_ok;
    logic [FW-1:0]        thr;
    logic [FW-1:0]        fill_inc;
    logic [NUM_PE*CFGW-1:0] cfg_flat;

    logic signed [SW-1:0] x_link    [NUM_PE+1];
    logic                 last_link [NUM_PE+1];
    logic signed [AW-1:0] psum_link [NUM_PE+1];

    assign in_ready = out_ready;
    assign beat     = in_valid && out_ready;
    assign cfg_ok   = cfg_valid && !in_valid && (cfg_pe_index < IW'(NUM_PE));
    assign cfg_flat = st_q.cfg;

    always_comb begin
        thr = FW'(NUM_PE);
        for (int i = 0; i < NUM_PE - 1; i++) begin
            thr = thr + FW'(st_q.cfg[i].dm1) + FW'(1);
        end
        fill_inc = (st_q.fill == '1) ? st_q.fill : st_q.fill + FW'(1);

        st_d = st_q;
        if (cfg_ok) begin
            st_d.cfg[cfg_pe_index[PIW-1:0]] = '{coeff: cfg_coeff,
                                                dm1:   cfg_depth_m1,
                                                mode:  mode_e'(cfg_mode)};
            st_d.fill = '0;
            st_d.oval = 1'b0;
        end else if (beat) begin
            st_d.fill = fill_inc;
            st_d.oval = (fill_inc >= thr);
        end else if (out_ready) begin
            st_d.oval = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < NUM_PE; i++) st_q.cfg[i].mode <= MODE_PASS;
        end else begin
            st_q <= st_d;
        end
    end

    assign x_link[0]    = in_sample;
    assign last_link[0] = in_row_last;
    assign psum_link[0] = '0;

    for (genvar g = 0; g < NUM_PE; g++) begin : g_pe
        sysmac_pe #(.SW(SW), .AW(AW), .MAXD(MAXD), .DW(DW)) u_pe (
            .clk      (clk),
            .rst_n    (rst_n),
            .beat     (beat),
            .clr_acc  (cfg_ok),
            .coeff    (st_q.cfg[g].coeff),
            .depth_m1 (st_q.cfg[g].dm1),
            .mode     (st_q.cfg[g].mode),
            .x_in     (x_link[g]),
            .last_in  (last_link[g]),
            .psum_in  (psum_link[g]),
            .x_out    (x_link[g+1]),
            .last_out (last_link[g+1]),
            .psum_out (psum_link[g+1])
        );
    end

    assign out_valid = st_q.oval;
    assign out_data  = psum_link[NUM_PE];

endmodule

// File: rtl/sysmac_chain_chk.sv
module sysmac_chain_chk #(
    parameter int NUM_PE = 4,
    parameter int IW     = 3,
    parameter int AW     = 40,
    parameter int CW     = 84
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_valid,
    input logic [IW-1:0] cfg_pe_index,
    input logic          in_valid,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [AW-1:0] out_data,
    input logic [CW-1:0] cfg_flat
);
    // R1: reset leaves no result pending
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_data == '0));

    // R9: a stalled valid result is held unchanged
    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R9: the result moves only on a beat
    p_no_beat_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> $stable(out_data));

    // R10: a drained result is not shown again
    p_drain_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !in_valid) |=> !out_valid);

    // R7: writes are blocked while input is offered
    p_busy_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && in_valid) |=> $stable(cfg_flat));

    // R8: out-of-range index changes nothing
    p_bad_index_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && cfg_pe_index >= IW'(NUM_PE)) |=> $stable(cfg_flat));

endmodule

bind sysmac_chain sysmac_chain_chk #(
    .NUM_PE (NUM_PE),
    .IW     (IW),
    .AW     (AW),
    .CW     (NUM_PE * (SW + DW + 2))
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_valid    (cfg_valid),
    .cfg_pe_index (cfg_pe_index),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_data     (out_data),
    .cfg_flat     (cfg_flat)
);

// File: tb/sysmac_chain_tb.sv
`timescale 1ns/1ps
module sysmac_chain_tb;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cfg_valid = 1'b0;
    logic [2:0]         cfg_pe_index = '0;
    logic signed [15:0] cfg_coeff = '0;
    logic [2:0]         cfg_depth_m1 = '0;
    logic [1:0]         cfg_mode = '0;
    logic               in_valid = 1'b0;
    logic               in_ready;
    logic signed [15:0] in_sample = '0;
    logic               in_row_last = 1'b0;
    logic               out_valid;
    logic               out_ready = 1'b1;
    logic signed [39:0] out_data;

    always #2 clk = ~clk;

    sysmac_chain u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_pe_index(cfg_pe_index),
        .cfg_coeff(cfg_coeff), .cfg_depth_m1(cfg_depth_m1), .cfg_mode(cfg_mode),
        .in_valid(in_valid), .in_ready(in_ready), .in_sample(in_sample),
        .in_row_last(in_row_last), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data)
    );

    int checks = 0;
    int failures = 0;

    // bench model state
    longint bc [4];
    int     bd [4];
    int     bm [4];
    longint xs [4096];
    bit     lasts [4096];
    int     nb;
    int     fs;
    bit     ev;
    longint ey;
    int unsigned seed = 32'h1234_5678;

    function automatic logic signed [15:0] rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed[30:15];
    endfunction

    function automatic int thr();
        return 4 + bd[0] + bd[1] + bd[2];
    endfunction

    function automatic longint exp_y(int n);
        longint acc = 0;
        int p = 0;
        for (int i = 0; i < 4; i++) begin
            int m = n - 3 - p;
            if (m >= 0) begin
                if (bm[i] == 1) acc += bc[i] * xs[m];
                else if (bm[i] == 2 && lasts[m]) begin
                    longint s = xs[m];
                    int k = m - 1;
                    while (k >= 0 && !lasts[k]) begin
                        s += xs[k];
                        k--;
                    end
                    acc += bc[i] * s;
                end
            end
            p += bd[i];
        end
        return acc;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; cfg_valid = 1'b0; out_ready = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin bc[i] = 0; bd[i] = 1; bm[i] = 0; end
        nb = 0; fs = 0; ev = 1'b0; ey = 0;
    endtask

    task automatic wcfg(input int idx, input int c, input int d, input int m);
        cfg_valid = 1'b1; cfg_pe_index = 3'(idx); cfg_coeff = 16'(c);
        cfg_depth_m1 = 3'(d - 1); cfg_mode = 2'(m); in_valid = 1'b0; out_ready = 1'b1;
        @(posedge clk);
        if (idx < 4) begin
            bc[idx] = c; bd[idx] = d; bm[idx] = (m == 3) ? 0 : m;
            fs = 0; ev = 1'b0;
        end
        @(negedge clk);
        cfg_valid = 1'b0;
    endtask

    // one clock: drive at negedge, model at posedge, check at next negedge
    task automatic cyc(input bit v, input logic signed [15:0] s, input bit l,
                       input bit rdy, input string tag);
        in_valid = v; in_sample = s; in_row_last = l; out_ready = rdy;
        @(posedge clk);
        if (v && rdy) begin
            xs[nb] = s; lasts[nb] = l; nb++;
            if (fs < 255) fs++;
            ev = (fs >= thr());
            if (ev) ey = exp_y(nb - 1);
        end else if (rdy) begin
            ev = 1'b0;
        end
        @(negedge clk);
        chk(in_ready == rdy, "R2 in_ready", longint'(in_ready), longint'(rdy));
        chk(out_valid == ev, {tag, " valid"}, longint'(out_valid), longint'(ev));
        if (ev) chk(out_data == ey[39:0], {tag, " data"}, longint'(out_data), ey);
        in_valid = 1'b0; in_row_last = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int dv [3] = '{1, 3, 8};
        do_reset();
        // R1: reset state
        chk(out_valid == 1'b0, "R1 valid", longint'(out_valid), 0);
        chk(out_data == '0, "R1 data", longint'(out_data), 0);
        // R1: default pass config gives zero output after fill
        for (int k = 0; k < 10; k++) cyc(1'b1, rnd(), 1'b0, 1'b1, "R1");

        // R3: plain convolution, unit spacing
        do_reset();
        wcfg(0, 3, 1, 1); wcfg(1, -2, 1, 1); wcfg(2, 5, 1, 1); wcfg(3, 7, 1, 1);
        for (int k = 0; k < 30; k++) cyc(1'b1, rnd(), 1'b0, 1'b1, "R3");

        // R4/R5/R11: depth sweep with mixed modes
        for (int a = 0; a < 3; a++)
            for (int b = 0; b < 3; b++)
                for (int c = 0; c < 3; c++) begin
                    int idx = a * 9 + b * 3 + c;
                    do_reset();
                    wcfg(0, 11 + idx, dv[a], (idx % 4 == 1) ? 0 : 1);
                    wcfg(1, -7 - idx, dv[b], 1);
                    wcfg(2, 300 - idx, dv[c], (idx % 5 == 2) ? 3 : 1);
                    wcfg(3, -4, dv[(idx + 1) % 3], 1);
                    for (int k = 0; k < 14 + dv[a] + dv[b] + dv[c]; k++)
                        cyc(1'b1, rnd(), 1'b0, 1'b1, "R4");
                end

        // R5: pass PE with large coefficient contributes nothing
        do_reset();
        wcfg(0, 2, 2, 1); wcfg(1, 9999, 3, 0); wcfg(2, -1, 1, 1); wcfg(3, 4, 1, 3);
        for (int k = 0; k < 25; k++) cyc(1'b1, rnd(), 1'b0, 1'b1, "R5");

        // R6: row accumulation on PE0 and PE2, rows of varying length
        do_reset();
        wcfg(0, 3, 2, 2); wcfg(1, -5, 1, 1); wcfg(2, 6, 3, 2); wcfg(3, 0, 1, 0);
        for (int r = 1; r <= 6; r++)
            for (int k = 0; k < r; k++) cyc(1'b1, rnd(), k == r - 1, 1'b1, "R6");
        for (int k = 0; k < 12; k++) cyc(1'b1, 16'sd0, 1'b0, 1'b1, "R6");

        // R3: full-scale negative operands, exact signed result
        do_reset();
        for (int i = 0; i < 4; i++) wcfg(i, -32768, 1, 1);
        for (int k = 0; k < 12; k++) cyc(1'b1, -16'sd32768, 1'b0, 1'b1, "R3 extreme");

        // R7: write while input is offered is ignored
        do_reset();
        wcfg(0, 5, 1, 1); wcfg(1, 1, 1, 1); wcfg(2, 1, 2, 1); wcfg(3, -3, 1, 1);
        cfg_valid = 1'b1; cfg_pe_index = 3'd0; cfg_coeff = 16'sd1000;
        cfg_depth_m1 = 3'd5; cfg_mode = 2'd1;
        cyc(1'b1, rnd(), 1'b0, 1'b1, "R7");
        cfg_valid = 1'b0;
        for (int k = 0; k < 15; k++) cyc(1'b1, rnd(), 1'b0, 1'b1, "R7");

        // R8: out-of-range index ignored
        wcfg(5, 777, 8, 2);
        wcfg(7, -777, 4, 1);
        for (int k = 0; k < 10; k++) cyc(1'b1, rnd(), 1'b0, 1'b1, "R8");

        // R9: stalls with input offered, R10: drain without a beat
        for (int k = 0; k < 20; k++) begin
            cyc(1'b1, rnd(), 1'b0, (k % 3) != 1, "R9");
            if (k % 4 == 3) cyc(1'b0, 16'sd0, 1'b0, 1'b1, "R10");
        end
        cyc(1'b0, 16'sd0, 1'b0, 1'b0, "R9 idle stall");
        cyc(1'b0, 16'sd0, 1'b0, 1'b1, "R10");
        cyc(1'b0, 16'sd0, 1'b0, 1'b1, "R10");

        // R11: accepted write restarts the fill count
        for (int k = 0; k < 5; k++) cyc(1'b1, rnd(), 1'b0, 1'b1, "R11");
        wcfg(1, 2, 4, 1);
        chk(out_valid == 1'b0, "R11 cleared", longint'(out_valid), 0);
        for (int k = 0; k < 16; k++) cyc(1'b1, rnd(), 1'b0, 1'b1, "R11");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule